// File: doc/BRIEF.md
# Parity-Checked S-box Byte Lane

This block is a single byte lane of a first-round substitution stage that detects faults while it runs. A plaintext byte and a key byte are combined by bitwise XOR. The combined byte gets an even parity bit, and the 9-bit word is checked before it reaches the substitution. The substitution returns the substituted byte together with a parity bit. That parity bit is looked up in a separate parity table and is not recomputed from the output, so the 9-bit result is checked a second time. If either check fails, the data is replaced by a reserved error word, `9'h001`, and an error flag is raised. Two 9-bit XOR masks, one at each check point, let a test flip bits on purpose.

Operands enter through a valid/ready handshake. A transfer happens on a rising clock edge where `in_valid` and `in_ready` are both high. The result sits in a single output register that presents `out_valid`. `in_ready` equals `!out_valid || out_ready`, so a new operand can be taken in the same cycle that the held result is consumed. While `out_valid` is high and `out_ready` is low, the held word does not change and no input is taken. Once a result is consumed and no new operand arrives, the register is cleared to zero, so every operation starts from the same state.

Top module: `sbox_ced_lane`

## Requirements
- R1: One cycle after an operand is accepted with both fault masks zero, `out_valid` is high and `out_word[8:1]` equals the forward AES S-box of `pt_byte ^ key_byte`. The S-box is the GF(2^8) inverse (polynomial 0x11B, with 0 mapping to 0) followed by the affine map with constant 0x63.
- R2: Whenever `out_valid` is high and `err_flag` is low, `out_word[0]` equals the XOR of `out_word[8:1]` (even parity).
- R3: If `flt_in` has exactly one bit set, the result is `out_word = 9'h001` with `err_flag` high. The mask is XORed onto the input word `{data, parity}`, where bit 0 is the parity bit.
- R4: If `flt_out` has exactly one bit set, the result is `out_word = 9'h001` with `err_flag` high. The mask is XORed onto the S-box output word in the same bit layout.
- R5: `err_flag` can only be high together with `out_valid` high and `out_word = 9'h001`.
- R6: After a result is consumed (`out_valid && out_ready`) and no operand is accepted in that cycle, the next cycle shows `out_valid = 0`, `out_word = 0` and `err_flag = 0`.
- R7: While `out_valid` is high and `out_ready` is low, `out_word`, `err_flag` and `out_valid` hold their values and `in_ready` is low.
- R8: After reset, `out_valid = 0`, `out_word = 0`, `err_flag = 0` and `in_ready = 1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Lane can take an operand |
| pt_byte | input | 8 | Plaintext byte |
| key_byte | input | 8 | Key byte |
| flt_in | input | 9 | Fault mask at the input check point |
| flt_out | input | 9 | Fault mask at the output check point |
| out_valid | output | 1 | Result held in the output register |
| out_ready | input | 1 | Consumer takes the result |
| out_word | output | 9 | {substituted byte, parity}, or 9'h001 on error |
| err_flag | output | 1 | Held word is the error code |

## Verification
The assertions check on every cycle that the error flag only ever appears with the reserved word. They also check that every error-free result has even parity, that a stalled result holds, that an accepted operand yields a result one cycle later, and that a consumed result clears the register. The bench scenarios are what show the data values. They sweep all 256 XOR inputs against an S-box model computed independently, and they confirm that every single-bit fault at either check point produces the error word. No per-cycle property can show either of these.

// File: rtl/sbox_ced_pkg.sv
package sbox_ced_pkg;
  localparam int DW = 8;
  localparam int WW = DW + 1;
  localparam int NENT = 1 << DW;
  localparam logic [WW-1:0] ERR_WORD = {{DW{1'b0}}, 1'b1};

  function automatic logic par_even(input logic [DW-1:0] d);
    return ^d;
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    logic [7:0] t;
    r = 8'h00;
    t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ t;
      t = t[7] ? ({t[6:0], 1'b0} ^ 8'h1B) : {t[6:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] r;
    logic [7:0] p;
    logic [7:0] e;
    r = 8'h01;
    p = x;
    e = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox_fwd(input logic [7:0] x);
    logic [7:0] b;
    b = gf_inv(x);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [NENT-1:0] build_ptab();
    logic [NENT-1:0] t;
    for (int i = 0; i < NENT; i++) t[i] = par_even(sbox_fwd(8'(i)));
    return t;
  endfunction
endpackage

// File: rtl/sbox_par_check.sv
module sbox_par_check
  import sbox_ced_pkg::*;
(
  input  logic [WW-1:0] word,
  output logic          ok
);
  always_comb ok = (par_even(word[WW-1:1]) == word[0]);
endmodule

// File: rtl/sbox_core.sv
module sbox_core
  import sbox_ced_pkg::*;
(
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  always_comb dout = sbox_fwd(din);
endmodule

// File: rtl/sbox_par_table.sv
module sbox_par_table
  import sbox_ced_pkg::*;
(
  input  logic [DW-1:0] idx,
  output logic          par
);
  localparam logic [NENT-1:0] PTAB = build_ptab();
  always_comb par = PTAB[idx];
endmodule

// File: rtl/sbox_ced_lane.sv
module sbox_ced_lane
  import sbox_ced_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] pt_byte,
  input  logic [DW-1:0] key_byte,
  input  logic [WW-1:0] flt_in,
  input  logic [WW-1:0] flt_out,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [WW-1:0] out_word,
  output logic          err_flag
);
  logic [DW-1:0] mix;
  logic [WW-1:0] w_in;
  logic [WW-1:0] w_out;
  logic [DW-1:0] sub;
  logic          sub_par;
  logic [1:0]    ok;
  logic [WW-1:0] result;
  logic          take;
  logic          drain;

  always_comb begin
    mix  = pt_byte ^ key_byte;
    w_in = {mix, par_even(mix)} ^ flt_in;
  end

  sbox_core u_core (.din(w_in[WW-1:1]), .dout(sub));
  sbox_par_table u_ptab (.idx(w_in[WW-1:1]), .par(sub_par));

  always_comb w_out = {sub, sub_par} ^ flt_out;

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_chk
      sbox_par_check u_chk (.word(g == 0 ? w_in : w_out), .ok(ok[g]));
    end
  endgenerate

  always_comb begin
    result   = (&ok) ? w_out : ERR_WORD;
    in_ready = !out_valid || out_ready;
    take     = in_valid && in_ready;
    drain    = out_valid && out_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      err_flag  <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_word  <= result;
      err_flag  <= !(&ok);
    end else if (drain) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      err_flag  <= 1'b0;
    end
  end
endmodule

// File: rtl/sbox_ced_lane_chk.sv
module sbox_ced_lane_chk
  import sbox_ced_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [WW-1:0] out_word,
  input logic          err_flag
);
  // R5: the flag only appears together with the reserved word
  p_flag_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> (out_valid && out_word == ERR_WORD));

  // R2: good results carry even parity
  p_good_parity_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !err_flag) |-> (^out_word[WW-1:1]) == out_word[0]);

  // R7: a stalled result holds
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(err_flag)));

  // R7: no input is taken during a stall
  p_stall_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R1: an accepted operand gives a result one cycle later
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R6: a consumed result with no new operand clears the register
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> (!out_valid && out_word == '0 && !err_flag));
endmodule

bind sbox_ced_lane sbox_ced_lane_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word), .err_flag(err_flag)
);

// File: tb/tb_sbox_ced_lane.sv
`timescale 1ns/1ps
module tb_sbox_ced_lane;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] pt_byte = '0;
  logic [7:0] key_byte = '0;
  logic [8:0] flt_in = '0;
  logic [8:0] flt_out = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [8:0] out_word;
  logic       err_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [9:0] expq[$];
  string      tagq[$];

  always #2 clk = ~clk;

  sbox_ced_lane dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .pt_byte(pt_byte), .key_byte(key_byte), .flt_in(flt_in), .flt_out(flt_out),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word), .err_flag(err_flag)
  );

  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (a[i]) p = p ^ (16'(b) << i);
    for (int k = 15; k >= 8; k--) if (p[k]) p = p ^ (16'h011B << (k - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] m_sbox(input logic [7:0] x);
    logic [7:0] inv;
    logic [7:0] s;
    logic [7:0] c;
    inv = 8'h00;
    for (int y = 1; y < 256; y++) if (m_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
    c = 8'h63;
    for (int i = 0; i < 8; i++)
      s[i] = inv[i] ^ inv[(i + 4) % 8] ^ inv[(i + 5) % 8] ^ inv[(i + 6) % 8] ^ inv[(i + 7) % 8] ^ c[i];
    return s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] p, input logic [7:0] k, input logic [8:0] fi,
                      input logic [8:0] fo, input logic [9:0] exp, input string tag);
    @(negedge clk);
    in_valid = 1'b1; pt_byte = p; key_byte = k; flt_in = fi; flt_out = fo;
    expq.push_back(exp);
    tagq.push_back(tag);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0; flt_in = '0; flt_out = '0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare consumed results against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check("R1 unexpected result", 32'(out_word), 32'h1FF);
        end else begin
          logic [9:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          check(t, 32'({err_flag, out_word}), 32'(e));
        end
      end
    end
  end

  function automatic logic [9:0] good(input logic [7:0] x);
    logic [7:0] s;
    s = m_sbox(x);
    return {1'b0, s, ^s};
  endfunction

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R8 out_valid", 32'(out_valid), 0);
    check("R8 out_word", 32'(out_word), 0);
    check("R8 err_flag", 32'(err_flag), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R8 in_ready", 32'(in_ready), 1);

    // known model anchor values
    check("R1 model 00", 32'(m_sbox(8'h00)), 32'h63);
    check("R1 model 01", 32'(m_sbox(8'h01)), 32'h7C);
    check("R1 model 53", 32'(m_sbox(8'h53)), 32'hED);

    // R1 R2: full sweep of XOR inputs, back to back, varying key
    for (int i = 0; i < 256; i++) begin
      logic [7:0] k;
      k = 8'(i * 37 + 11);
      send(8'(i) ^ k, k, '0, '0, good(8'(i)), "R1 sweep");
    end
    idle(3);

    // R6: cleared after consumption
    #1;
    check("R6 out_valid", 32'(out_valid), 0);
    check("R6 out_word", 32'(out_word), 0);
    check("R6 err_flag", 32'(err_flag), 0);

    // R3: single bit faults at the input check point
    for (int b = 0; b < 9; b++)
      for (int v = 0; v < 4; v++)
        send(8'(v * 71 + b), 8'h5A, 9'(1 << b), '0, 10'h201, "R3 input fault");
    // R4: single bit faults at the output check point
    for (int b = 0; b < 9; b++)
      for (int v = 0; v < 4; v++)
        send(8'(v * 53 + b), 8'hC3, '0, 9'(1 << b), 10'h201, "R4 output fault");
    idle(3);
    #1;
    check("R5 flag cleared", 32'(err_flag), 0);

    // R7: back-pressure holds the result
    @(negedge clk);
    out_ready = 1'b0;
    send(8'h12, 8'h34, '0, '0, good(8'h26), "R7 stalled result");
    @(negedge clk);
    in_valid = 1'b0;
    pt_byte = 8'hFF;
    for (int c = 0; c < 3; c++) begin
      #1;
      check("R7 valid held", 32'(out_valid), 1);
      check("R7 word held", 32'(out_word), 32'(good(8'h26)));
      check("R7 in_ready low", 32'(in_ready), 0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    idle(3);
    #1;
    check("R6 clear after stall", 32'(out_valid), 0);
    check("R1 scoreboard drained", 32'(expq.size()), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule